// File: doc/BRIEF.md
# Bootstrap Triplet Byte Loader

This block sits behind the receiver of whichever port has been chosen for bootstrap loading. It accepts one byte at a time and groups the bytes into threes. The first byte of each group is the upper half of a 16-bit target address, the second byte is the lower half, and the third byte is the value to write. Once a group is complete, the block issues a single write. The write goes to memory when the top address bit is clear, and to an internal register when that bit is set.

A watchdog runs alongside the loader. Each accepted byte restarts it. If no byte arrives within a programmable number of clock cycles, the watchdog raises a timeout pulse and throws away any group that is only partly received. The watchdog can be switched off. When the loader is taken out of bootstrap operation, it ignores incoming bytes and drops any partial group.

Top module: `boot_triplet_loader`

## Requirements
- R1: After reset, `mem_we`, `reg_we` and `wdt_timeout` are low and the next accepted byte is taken as an address-high byte.
- R2: Bytes are accepted only while `boot_active` and `rx_valid` are both high. A group of bytes b0, b1, b2 in that order produces a write with address {b0,b1} and data b2. When b0[7] is 0, the write appears on `mem_addr`/`mem_wdata` with `mem_we`.
- R3: Each write strobe is high for exactly one cycle. It rises in the cycle that follows the clock edge at which the third byte is accepted.
- R4: When b0[7] is 1, `reg_we` pulses, `reg_index` equals {b0[6:0],b1} and `reg_wdata` equals b2. `mem_we` stays low for that group.
- R5: Cycles with `rx_valid` low between bytes have no effect on the grouping.
- R6: While `boot_active` is low, bytes are ignored and no write is issued. Any partly received group is discarded, so the next accepted byte is again an address-high byte.
- R7: With the watchdog enabled, `wdt_timeout` pulses for one cycle exactly TIMEOUT_CYCLES cycles after the edge of the last accepted byte. Any accepted byte before that restarts the count.
- R8: With `wdt_enable` low, `wdt_timeout` stays low and the count is held at zero. After the watchdog is enabled again, a full TIMEOUT_CYCLES must pass before a timeout.
- R9: A timeout discards a partly received group.
- R10: If no byte arrives, the timeout pulse repeats every TIMEOUT_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_active | input | 1 | High while bootstrap loading is in effect |
| wdt_enable | input | 1 | Enables the inactivity watchdog |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| reg_we | output | 1 | One-cycle internal register write strobe |
| reg_index | output | 15 | Internal register index |
| reg_wdata | output | 8 | Internal register write data |
| wdt_timeout | output | 1 | One-cycle pulse when bytes stop arriving |

## Verification
The hardest cases to reach from the ports involve the hidden byte position inside a group. The ports give no direct view of it: a partial group left behind by a timeout or by leaving bootstrap mode shows up only through where the next write lands. The stimulus therefore leaves one or two stray bytes behind, lets the watchdog expire or drops `boot_active`, and then sends a complete group with a distinct address. The expected write shows the position was reset. Timeout timing is checked by counting edges from the accepted byte, with a small timeout parameter, and by sampling the cycle just before and the cycle just after the expected pulse.

// File: rtl/boot_triplet_loader.sv
module boot_triplet_loader #(
  parameter int TIMEOUT_CYCLES = 100_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_active,
  input  logic        wdt_enable,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        reg_we,
  output logic [14:0] reg_index,
  output logic [7:0]  reg_wdata,
  output logic        wdt_timeout
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [1:0]    pos;
  logic [7:0]    hi_q, lo_q;
  logic [CW-1:0] cnt;

  wire accept = boot_active && rx_valid;
  wire wd_run = boot_active && wdt_enable && !accept;
  wire expire = wd_run && (cnt == LAST);
  wire done   = accept && (pos == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n || !boot_active || expire) begin
      pos <= 2'd0;
    end else if (accept) begin
      pos <= done ? 2'd0 : pos + 2'd1;
      if (pos == 2'd0) hi_q <= rx_byte;
      if (pos == 2'd1) lo_q <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      reg_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      reg_index <= '0;
      reg_wdata <= '0;
    end else begin
      mem_we <= done && !hi_q[7];
      reg_we <= done && hi_q[7];
      if (done && !hi_q[7]) begin
        mem_addr  <= {hi_q, lo_q};
        mem_wdata <= rx_byte;
      end
      if (done && hi_q[7]) begin
        reg_index <= {hi_q[6:0], lo_q};
        reg_wdata <= rx_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !wd_run || expire) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wdt_timeout <= 1'b0;
    else        wdt_timeout <= expire;
  end

  p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && reg_we));
  p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || reg_we) |=> !(mem_we || reg_we));
  p_mem_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_addr[15]);
  p_inactive_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !(mem_we || reg_we));
  p_byte_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wdt_timeout);
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_enable |=> !wdt_timeout);
  p_timeout_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);
endmodule

// File: tb/boot_triplet_loader_bench.sv
module boot_triplet_loader_bench;
  localparam int T = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_active = 1'b0;
  logic        wdt_enable = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        mem_we, reg_we, wdt_timeout;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, reg_wdata;
  logic [14:0] reg_index;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  boot_triplet_loader #(.TIMEOUT_CYCLES(T)) u_boot_triplet_loader (
    .clk(clk), .rst_n(rst_n), .boot_active(boot_active), .wdt_enable(wdt_enable),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_index(reg_index),
    .reg_wdata(reg_wdata), .wdt_timeout(wdt_timeout));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic send_group(input logic [7:0] b0, b1, b2);
    send_byte(b0);
    send_byte(b1);
    send_byte(b2);
  endtask

  task automatic expect_mem(input string req, input logic [15:0] a, input logic [7:0] d);
    check({req, " mem_we"}, mem_we, 1);
    check({req, " reg_we"}, reg_we, 0);
    check({req, " addr"}, mem_addr, a);
    check({req, " data"}, mem_wdata, d);
    tick();
    check({req, " strobe drop"}, mem_we, 0);
  endtask

  task automatic t_reset();
    check("R1 mem_we", mem_we, 0);
    check("R1 reg_we", reg_we, 0);
    check("R1 timeout", wdt_timeout, 0);
  endtask

  task automatic t_mem_write();
    send_byte(8'h12);
    check("R3 no early strobe", mem_we, 0);
    send_byte(8'h34);
    check("R3 no early strobe", mem_we, 0);
    send_byte(8'hA5);
    expect_mem("R2 R3", 16'h1234, 8'hA5);
    send_group(8'h7F, 8'hFF, 8'h00);
    expect_mem("R2 top address", 16'h7FFF, 8'h00);
  endtask

  task automatic t_reg_write();
    send_group(8'h81, 8'h22, 8'h5C);
    check("R4 reg_we", reg_we, 1);
    check("R4 mem_we", mem_we, 0);
    check("R4 index", reg_index, 15'h0122);
    check("R4 data", reg_wdata, 8'h5C);
    tick();
    check("R4 R3 reg strobe drop", reg_we, 0);
    send_group(8'hFF, 8'hFF, 8'h99);
    check("R4 max index", reg_index, 15'h7FFF);
    check("R4 mem_we max", mem_we, 0);
    tick();
  endtask

  task automatic t_gaps();
    send_byte(8'h03);
    repeat (3) tick();
    send_byte(8'h04);
    tick();
    send_byte(8'h05);
    expect_mem("R5 gaps", 16'h0304, 8'h05);
  endtask

  task automatic t_inactive();
    send_byte(8'h11);
    boot_active = 1'b0;
    tick();
    for (int i = 0; i < 3; i++) begin
      send_byte(8'h20 + 8'(i));
      check("R6 ignored byte", mem_we | reg_we, 0);
    end
    tick();
    check("R6 no write while inactive", mem_we | reg_we, 0);
    boot_active = 1'b1;
    send_group(8'h01, 8'h02, 8'h03);
    expect_mem("R6 partial discarded", 16'h0102, 8'h03);
  endtask

  task automatic t_wdt_timeout();
    wdt_enable = 1'b1;
    send_byte(8'h40);
    repeat (T / 2) tick();
    send_byte(8'h41);
    repeat (T - 1) tick();
    check("R7 before expiry", wdt_timeout, 0);
    tick();
    check("R7 timeout pulse", wdt_timeout, 1);
    tick();
    check("R7 pulse width", wdt_timeout, 0);
    repeat (T - 2) tick();
    check("R10 before repeat", wdt_timeout, 0);
    tick();
    check("R10 repeat pulse", wdt_timeout, 1);
    send_group(8'h05, 8'h06, 8'h07);
    expect_mem("R9 partial discarded", 16'h0506, 8'h07);
  endtask

  task automatic t_wdt_disable();
    int seen = 0;
    wdt_enable = 1'b0;
    tick();
    for (int i = 0; i < 3 * T; i++) begin
      tick();
      seen += int'(wdt_timeout);
    end
    check("R8 no timeout disabled", seen, 0);
    wdt_enable = 1'b1;
    repeat (T - 1) tick();
    check("R8 full period after enable", wdt_timeout, 0);
    tick();
    check("R8 timeout after enable", wdt_timeout, 1);
    wdt_enable = 1'b0;
    tick();
  endtask

  initial begin
    boot_active = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mem_write();
    t_reg_write();
    t_gaps();
    t_inactive();
    t_wdt_timeout();
    t_wdt_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule